// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Flag Generation

This block is the arithmetic and logic core of a small accumulator-style processor. It is purely combinational. In the same cycle it takes a four-bit operation select, the accumulator byte, a second operand byte and the current flag byte. It returns a result byte and the next flag byte, so the surrounding datapath can register both on its own clock edge.

The flag byte keeps a fixed layout:

| Bit | Flag |
|-----|------|
| 7 | sign |
| 6 | zero |
| 4 | half carry |
| 2 | parity/overflow |
| 1 | subtract |
| 0 | carry |

Bits 5 and 3 are spare. Each operation writes only the flags it owns, and every other flag bit, including the spare bits, is copied from the incoming byte.

There is no stored state, so the block has no state machine. The operation select decides which one of four computation paths drives the result and the flags:

- the shared adder (add, subtract, compare, increment, decrement, negate);
- the bitwise logic unit (AND, OR, XOR);
- the decimal adjuster;
- the direct flag path (complement, set carry, complement carry, pass).

The adder is the only path whose result depends on the carry chain. Half carry is the carry out of bit 3 when adding, and the borrow into bit 4 when subtracting. Overflow is two's-complement signed overflow. Parity is 1 when the result holds an even number of one bits.

Top module: `alu8_flag_unit`

## Requirements
- R1: Operation encodings on `op_i` are 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 CMP, 5 AND, 6 OR, 7 XOR, 8 INC, 9 DEC, 10 NEG, 11 CPL, 12 SCF, 13 CCF, 14 DAA and 15 PASS. For every operation, output flag bits 5 and 3 equal the input flag bits 5 and 3.
- R2: ADD gives A+B and ADC gives A+B+C_in. Both set S from bit 7 and Z when the result is zero. They set H to the carry out of bit 3, P/V to signed overflow and C to the carry out of bit 7, and they clear N (bit 1).
- R3: SUB gives A−B and SBC gives A−B−C_in. Both set N. H is the borrow into bit 4, P/V is signed overflow and C is the borrow out of bit 7. S and Z come from the result.
- R4: CMP produces the same flags as SUB, but the result output equals A unchanged.
- R5: NEG gives 0−A, with flags computed as for SUB with a minuend of 0. As a result, C=1 exactly when A≠0, and P/V=1 exactly when A=0x80.
- R6: AND, OR and XOR give the bitwise result. S and Z come from the result and P/V is its parity (1 for an even count of ones). N and C are cleared. H is 1 for AND and 0 for OR and XOR.
- R7: INC gives A+1 with N=0, and DEC gives A−1 with N=1. S, Z, H and P/V are updated as for add or subtract, and C (bit 0) is left unchanged.
- R8: CPL gives the bitwise inverse of A and sets H and N. S, Z, P/V and C are unchanged.
- R9: SCF returns A, sets C and clears H and N. CCF returns A, copies the old C into H, inverts C and clears N. Both leave S, Z and P/V unchanged.
- R10: DAA adds or subtracts a correction, adding when N=0 and subtracting when N=1. The low nibble 6 is used when H=1 or the low nibble of A is greater than 9. 0x60 is used when C=1 or A is greater than 0x99. C becomes 1 if the 0x60 term was used. H becomes (A low nibble > 9) after an addition and (H and A low nibble < 6) after a subtraction. S and Z come from the result, P/V is parity, and N is unchanged.
- R11: PASS returns A and passes the flag byte through unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_i | input | 4 | Operation select, encoded as in R1 |
| acc_i | input | 8 | Accumulator byte |
| opnd_i | input | 8 | Second operand byte, used by the two-operand operations |
| flags_i | input | 8 | Incoming flag byte |
| result_o | output | 8 | Result byte |
| flags_o | output | 8 | Next flag byte |

## Verification
The block holds no state, so any fault shows up on the same evaluation as the inputs that trigger it. A bad carry-chain tap shows up as wrong H, C or P/V values on specific operand pairs. A mis-steered path shows up as a wrong result byte, or as a flag that changes when it should have been copied. The sweep covers every accumulator and operand pair for the two-operand operations, and every accumulator and flag-byte pair for the single-operand operations. A fault therefore appears at the first input combination that exposes it, rather than depending on a lucky pattern. The spare flag bits are compared on every vector, so any leak into them is caught at once.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    typedef enum logic [3:0] {
        OP_ADD  = 4'd0,
        OP_ADC  = 4'd1,
        OP_SUB  = 4'd2,
        OP_SBC  = 4'd3,
        OP_CMP  = 4'd4,
        OP_AND  = 4'd5,
        OP_OR   = 4'd6,
        OP_XOR  = 4'd7,
        OP_INC  = 4'd8,
        OP_DEC  = 4'd9,
        OP_NEG  = 4'd10,
        OP_CPL  = 4'd11,
        OP_SCF  = 4'd12,
        OP_CCF  = 4'd13,
        OP_DAA  = 4'd14,
        OP_PASS = 4'd15
    } alu_op_e;

    localparam int FLAG_S  = 7;
    localparam int FLAG_Z  = 6;
    localparam int FLAG_H  = 4;
    localparam int FLAG_PV = 2;
    localparam int FLAG_N  = 1;
    localparam int FLAG_C  = 0;

endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
    parameter int W = 8
) (
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         cin_i,
    input  logic         sub_i,
    output logic [W-1:0] sum_o,
    output logic         half_o,
    output logic         ovf_o,
    output logic         cout_o
);
    localparam int NIB = W / 2;

    logic [W-1:0] b_eff;
    logic         c_eff;
    logic [W:0]   full;
    logic [NIB:0] low;

    always_comb begin
        b_eff  = sub_i ? ~b_i : b_i;
        c_eff  = sub_i ? ~cin_i : cin_i;
        full   = {1'b0, a_i} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
        low    = {1'b0, a_i[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
        sum_o  = full[W-1:0];
        cout_o = sub_i ? ~full[W] : full[W];
        half_o = sub_i ? ~low[NIB] : low[NIB];
        ovf_o  = (a_i[W-1] == b_eff[W-1]) && (full[W-1] != a_i[W-1]);
    end

    // R2: adding zero with no carry-in must return the first operand and no carry
    always_comb begin
        if (!sub_i && !cin_i && b_i == '0) begin
            assert_add_zero_identity_R2: assert (sum_o == a_i && !cout_o && !ovf_o);
        end
    end

endmodule

// File: rtl/alu8_bitwise.sv
module alu8_bitwise
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  alu_op_e      op_i,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    output logic [W-1:0] res_o,
    output logic         even_o
);
    always_comb begin
        unique case (op_i)
            OP_AND:  res_o = a_i & b_i;
            OP_OR:   res_o = a_i | b_i;
            OP_XOR:  res_o = a_i ^ b_i;
            default: res_o = '0;
        endcase
        even_o = ~^res_o;
    end

    // R6: an AND result can never contain a bit absent from either operand
    always_comb begin
        if (op_i == OP_AND) begin
            assert_and_subset_R6: assert ((res_o & ~a_i) == '0 && (res_o & ~b_i) == '0);
        end
    end

endmodule

// File: rtl/alu8_decadj.sv
module alu8_decadj (
    input  logic [7:0] acc_i,
    input  logic       n_i,
    input  logic       h_i,
    input  logic       c_i,
    output logic [7:0] res_o,
    output logic       h_o,
    output logic       c_o
);
    logic       lo_fix;
    logic       hi_fix;
    logic [7:0] corr;

    always_comb begin
        lo_fix = h_i || (acc_i[3:0] > 4'd9);
        hi_fix = c_i || (acc_i > 8'h99);
        corr   = {(hi_fix ? 4'h6 : 4'h0), (lo_fix ? 4'h6 : 4'h0)};
        res_o  = n_i ? (acc_i - corr) : (acc_i + corr);
        c_o    = hi_fix;
        h_o    = n_i ? (h_i && (acc_i[3:0] < 4'd6)) : (acc_i[3:0] > 4'd9);
    end

    // R10: an incoming carry is never cleared by the adjustment
    always_comb begin
        if (c_i) begin
            assert_daa_carry_kept_R10: assert (c_o);
        end
    end

endmodule

// File: rtl/alu8_flag_unit.sv
module alu8_flag_unit
    import alu8_pkg::*;
(
    input  logic [3:0] op_i,
    input  logic [7:0] acc_i,
    input  logic [7:0] opnd_i,
    input  logic [7:0] flags_i,
    output logic [7:0] result_o,
    output logic [7:0] flags_o
);
    localparam int W = 8;

    alu_op_e      op;
    logic [W-1:0] add_a, add_b, add_sum;
    logic         add_cin, add_sub, add_h, add_v, add_c;
    logic [W-1:0] log_res;
    logic         log_even;
    logic [W-1:0] daa_res;
    logic         daa_h, daa_c;

    assign op = alu_op_e'(op_i);

    // operand steering for the shared adder
    always_comb begin
        add_a   = acc_i;
        add_b   = opnd_i;
        add_cin = 1'b0;
        add_sub = 1'b0;
        unique case (op)
            OP_ADC:         add_cin = flags_i[FLAG_C];
            OP_SUB, OP_CMP: add_sub = 1'b1;
            OP_SBC: begin
                add_sub = 1'b1;
                add_cin = flags_i[FLAG_C];
            end
            OP_INC:         add_b = 8'd1;
            OP_DEC: begin
                add_b   = 8'd1;
                add_sub = 1'b1;
            end
            OP_NEG: begin
                add_a   = 8'd0;
                add_b   = acc_i;
                add_sub = 1'b1;
            end
            default: ;
        endcase
    end

    alu8_addsub #(.W(W)) u_addsub (
        .a_i    (add_a),
        .b_i    (add_b),
        .cin_i  (add_cin),
        .sub_i  (add_sub),
        .sum_o  (add_sum),
        .half_o (add_h),
        .ovf_o  (add_v),
        .cout_o (add_c)
    );

    alu8_bitwise #(.W(W)) u_bitwise (
        .op_i   (op),
        .a_i    (acc_i),
        .b_i    (opnd_i),
        .res_o  (log_res),
        .even_o (log_even)
    );

    alu8_decadj u_decadj (
        .acc_i (acc_i),
        .n_i   (flags_i[FLAG_N]),
        .h_i   (flags_i[FLAG_H]),
        .c_i   (flags_i[FLAG_C]),
        .res_o (daa_res),
        .h_o   (daa_h),
        .c_o   (daa_c)
    );

    // result and flag selection per operation
    always_comb begin
        result_o = acc_i;
        flags_o  = flags_i;
        unique case (op)
            OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP, OP_NEG: begin
                result_o         = (op == OP_CMP) ? acc_i : add_sum;
                flags_o[FLAG_S]  = add_sum[W-1];
                flags_o[FLAG_Z]  = (add_sum == '0);
                flags_o[FLAG_H]  = add_h;
                flags_o[FLAG_PV] = add_v;
                flags_o[FLAG_N]  = add_sub;
                flags_o[FLAG_C]  = add_c;
            end
            OP_AND, OP_OR, OP_XOR: begin
                result_o         = log_res;
                flags_o[FLAG_S]  = log_res[W-1];
                flags_o[FLAG_Z]  = (log_res == '0);
                flags_o[FLAG_H]  = (op == OP_AND);
                flags_o[FLAG_PV] = log_even;
                flags_o[FLAG_N]  = 1'b0;
                flags_o[FLAG_C]  = 1'b0;
            end
            OP_INC, OP_DEC: begin
                result_o         = add_sum;
                flags_o[FLAG_S]  = add_sum[W-1];
                flags_o[FLAG_Z]  = (add_sum == '0);
                flags_o[FLAG_H]  = add_h;
                flags_o[FLAG_PV] = add_v;
                flags_o[FLAG_N]  = add_sub;
            end
            OP_CPL: begin
                result_o        = ~acc_i;
                flags_o[FLAG_H] = 1'b1;
                flags_o[FLAG_N] = 1'b1;
            end
            OP_SCF: begin
                flags_o[FLAG_C] = 1'b1;
                flags_o[FLAG_H] = 1'b0;
                flags_o[FLAG_N] = 1'b0;
            end
            OP_CCF: begin
                flags_o[FLAG_H] = flags_i[FLAG_C];
                flags_o[FLAG_C] = ~flags_i[FLAG_C];
                flags_o[FLAG_N] = 1'b0;
            end
            OP_DAA: begin
                result_o         = daa_res;
                flags_o[FLAG_S]  = daa_res[W-1];
                flags_o[FLAG_Z]  = (daa_res == '0);
                flags_o[FLAG_H]  = daa_h;
                flags_o[FLAG_PV] = ~^daa_res;
                flags_o[FLAG_C]  = daa_c;
            end
            default: ;
        endcase
    end

    // guards on the selected outputs
    always_comb begin
        assert_spare_bits_kept_R1: assert (flags_o[5] == flags_i[5] && flags_o[3] == flags_i[3]);
        if (op == OP_CMP) begin
            assert_cmp_keeps_acc_R4: assert (result_o == acc_i);
        end
        if (op == OP_AND || op == OP_OR || op == OP_XOR) begin
            assert_logic_clears_nc_R6: assert (!flags_o[FLAG_N] && !flags_o[FLAG_C]);
        end
        if (op == OP_INC || op == OP_DEC) begin
            assert_incdec_keep_carry_R7: assert (flags_o[FLAG_C] == flags_i[FLAG_C]);
        end
        if (op == OP_CPL) begin
            assert_cpl_inverts_R8: assert ((result_o ^ acc_i) == 8'hFF);
        end
        if (op == OP_PASS) begin
            assert_pass_unchanged_R11: assert (result_o == acc_i && flags_o == flags_i);
        end
    end

endmodule

// File: tb/alu8_flag_unit_tb.sv
`timescale 1ns/100ps
module alu8_flag_unit_tb;

    logic       clk = 1'b0;
    logic [3:0] op;
    logic [7:0] acc, opnd, fin;
    logic [7:0] res, fout;
    int         checks = 0;
    int         errors = 0;
    int         cycles = 0;
    bit         done   = 1'b0;

    always #4 clk = ~clk;

    alu8_flag_unit u_dut (
        .op_i     (op),
        .acc_i    (acc),
        .opnd_i   (opnd),
        .flags_i  (fin),
        .result_o (res),
        .flags_o  (fout)
    );

    function automatic string req_tag(input int o);
        case (o)
            0, 1:   return "R2";
            2, 3:   return "R3";
            4:      return "R4";
            5, 6, 7: return "R6";
            8, 9:   return "R7";
            10:     return "R5";
            11:     return "R8";
            12, 13: return "R9";
            14:     return "R10";
            default: return "R11";
        endcase
    endfunction

    function automatic int sgn(input int v);
        return (v > 127) ? v - 256 : v;
    endfunction

    // integer reference for add (sub=0) and subtract (sub=1)
    task automatic arith(input int x, input int y, input int ci, input bit sub,
                         output logic [7:0] r, output bit h, output bit v, output bit c);
        int t, lo, sv;
        if (!sub) begin
            t  = x + y + ci;
            lo = (x % 16) + (y % 16) + ci;
            sv = sgn(x) + sgn(y) + ci;
            c  = (t > 255);
            h  = (lo > 15);
        end else begin
            t  = x - y - ci;
            lo = (x % 16) - (y % 16) - ci;
            sv = sgn(x) - sgn(y) - ci;
            c  = (t < 0);
            h  = (lo < 0);
        end
        r = 8'(t);
        v = (sv > 127) || (sv < -128);
    endtask

    task automatic model(input int o, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f, output logic [7:0] er, output logic [7:0] ef);
        logic [7:0] r;
        bit h, v, c;
        int t;
        er = a;
        ef = f;
        case (o)
            0, 1, 2, 3, 4, 10: begin
                if (o == 10) arith(0, int'(a), 0, 1'b1, r, h, v, c);
                else arith(int'(a), int'(b), (o == 1 || o == 3) ? int'(f[0]) : 0,
                           (o >= 2), r, h, v, c);
                er = (o == 4) ? a : r;
                ef[7] = r[7]; ef[6] = (r == 0); ef[4] = h; ef[2] = v;
                ef[1] = (o >= 2); ef[0] = c;
            end
            5, 6, 7: begin
                r = (o == 5) ? (a & b) : (o == 6) ? (a | b) : (a ^ b);
                er = r;
                ef[7] = r[7]; ef[6] = (r == 0); ef[4] = (o == 5);
                ef[2] = ($countones(r) % 2 == 0); ef[1] = 0; ef[0] = 0;
            end
            8, 9: begin
                arith(int'(a), 1, 0, (o == 9), r, h, v, c);
                er = r;
                ef[7] = r[7]; ef[6] = (r == 0); ef[4] = h; ef[2] = v; ef[1] = (o == 9);
            end
            11: begin er = ~a; ef[4] = 1; ef[1] = 1; end
            12: begin ef[0] = 1; ef[4] = 0; ef[1] = 0; end
            13: begin ef[4] = f[0]; ef[0] = ~f[0]; ef[1] = 0; end
            14: begin
                t = int'(a);
                if (f[4] || (a % 16) > 9) t = f[1] ? t - 6 : t + 6;
                if (f[0] || a > 8'h99) begin
                    t = f[1] ? t - 96 : t + 96;
                    ef[0] = 1;
                end else ef[0] = 0;
                er = 8'(t);
                ef[4] = f[1] ? (f[4] && (a % 16) < 6) : ((a % 16) > 9);
                ef[7] = er[7]; ef[6] = (er == 0); ef[2] = ($countones(er) % 2 == 0);
            end
            default: ;
        endcase
    endtask

    task automatic apply(input int o, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] f);
        logic [7:0] er, ef;
        op = 4'(o); acc = a; opnd = b; fin = f;
        #0.5;
        model(o, a, b, f, er, ef);
        checks++;
        if (fout[5] != f[5] || fout[3] != f[3]) begin
            errors++;
            $display("FAIL R1 op=%0d a=%02h f=%02h spare actual=%02h expected=%02h",
                     o, a, f, fout & 8'h28, f & 8'h28);
        end
        checks++;
        if (res != er || fout != ef) begin
            errors++;
            $display("FAIL %s op=%0d a=%02h b=%02h f=%02h actual res=%02h fl=%02h expected res=%02h fl=%02h",
                     req_tag(o), o, a, b, f, res, fout, er, ef);
        end
        #0.5;
    endtask

    initial begin
        // idle state: pass operation on all-zero inputs (R11)
        apply(15, 8'h00, 8'h00, 8'h00);
        // two-operand operations, every A and B (R2 R3 R4 R6)
        for (int o = 0; o < 8; o++)
            for (int a = 0; a < 256; a++)
                for (int b = 0; b < 256; b++)
                    apply(o, 8'(a), 8'(b), 8'(a) ^ {4'(b), 4'(b >> 4)} ^ 8'hA5);
        // single-operand operations, every A and flag byte (R5 R7 R8 R9 R10 R11)
        for (int o = 8; o < 16; o++)
            for (int a = 0; a < 256; a++)
                for (int f = 0; f < 256; f++)
                    apply(o, 8'(a), 8'(a ^ f), 8'(f));
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!done && cycles > 195000) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired after %0d cycles, expected completion", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule